// File: doc/BRIEF.md
# Low-Power Fast Clock Request Controller

This controller decides, for every power mode, whether the fast internal oscillator runs and at which frequency. It also chooses the source of the main and peripheral clocks. A converter peripheral raises an asynchronous fast-clock request, and the controller answers according to the current mode:

- In the full-power modes nothing changes.
- In a gear-shifted stop mode the oscillator is lifted back to its configured base frequency.
- In the deepest modes the oscillator is started at 32 MHz, the clocks are switched onto it, and the low-power mode is suspended for as long as the request is held.

In the standby mode where the peripheral clock is gated, a timer wake event opens a fixed window. The window lasts long enough for the converter to raise its request. When the request later drops, the fast clock is kept for a fixed tail so that completion events can propagate. After that the controller signals that gated standby may resume.

All pins are plain control and status signals. There is no streaming data path, so no valid/ready handshake applies. The oscillator is modelled as the clock input of the block. The two asynchronous inputs pass through a two-flop synchronizer before they steer the clock selects. The oscillator enable is also driven straight from the raw inputs, so that a stopped oscillator can be started.

Top module: `lpfc_ctrl`

## Requirements
- R1: In modes 0, 1, 3, 4 and 6 (full-power run, sleep and stop), `osc_en`=1, `osc_freq`=`base_freq` and `clk_sel`=1 (oscillator). `fclk_req` changes none of these. Frequency codes are 0=4 MHz, 1=16, 2=24, 3=32.
- R2: In modes 2 and 5 (low-frequency run/sleep) with no request, `osc_en`=0 and `clk_sel`=0 (low-frequency clock). With an honoured request, `osc_en`=1, `osc_freq`=3 and `clk_sel`=1, with `lp_suspend`=0.
- R3: In mode 7 (gear-shifted stop), the oscillator runs with `osc_freq`=0 and `clk_sel`=1. An honoured request sets `osc_freq`=`base_freq`, and releasing it returns `osc_freq` to 0.
- R4: In mode 8 (deepest stop) and mode 9 (ungated standby), an honoured request sets `lp_suspend`=1, `osc_en`=1, `osc_freq`=3 and `clk_sel`=1. Its release returns them to `lp_suspend`=0, `osc_en`=0 and `clk_sel`=0.
- R5: In mode 10 (gated standby) with no activity, `osc_en`=0 and `clk_sel`=2 (clock gated). A rising `tmr_wake` sets `lp_suspend`=1, `osc_en`=1, `osc_freq`=3 and `clk_sel`=1.
- R6: The post-wake window lasts `WIN_CYC` (32) cycles. If no request arrives within it, the controller returns to `clk_sel`=2 and `lp_suspend`=0, pulses `lp_resume` for one cycle, and increments `wake_timeouts`.
- R7: In gated standby, after the request falls, the fast clock stays selected for `TAIL_CYC` (32) cycles beyond the synchronizer delay. The controller then pulses `lp_resume` and selects the gated clock, and `wake_timeouts` does not change.
- R8: A request that rises during the release tail cancels the tail. `clk_sel` stays 1 without interruption, and a later release restarts a full tail.
- R9: When `ovr_run` or `ovr_stop` is 1, `fclk_req` is ignored in every mode. The outputs keep the values they would have without a request.
- R10: `fclk_req` reaches `osc_en` combinationally. It reaches `clk_sel`, `osc_freq` and `lp_suspend` after two `clk_osc` edges.
- R11: `tmr_wake` has no effect outside mode 10.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_osc | input | 1 | Fast oscillator clock (modelled as running) |
| rst_n | input | 1 | Asynchronous active-low reset |
| pmode | input | 4 | Power-mode code 0..10 |
| fclk_req | input | 1 | Asynchronous fast-clock request from the converter |
| tmr_wake | input | 1 | Asynchronous timer wake event |
| ovr_run | input | 1 | Run-mode clock override; set disables request handling |
| ovr_stop | input | 1 | Stop-mode clock override; set disables request handling |
| base_freq | input | 2 | Configured base oscillator frequency code |
| osc_en | output | 1 | Oscillator enable |
| osc_freq | output | 2 | Oscillator frequency code |
| clk_sel | output | 2 | Clock source: 0 low-frequency, 1 oscillator, 2 gated |
| lp_suspend | output | 1 | Low-power mode suspended |
| lp_resume | output | 1 | One-cycle pulse: gated standby may resume |
| wake_timeouts | output | TOW | Count of wake windows that expired without a request |

## Verification
The hardest situation to reach is a request that rises again inside the release tail of gated standby. It needs a wake edge, then a request inside the 32-cycle window, then a release, and then a second rising edge timed to land after the synchronizer delay but before the tail runs out. The stimulus builds this from one directed sequence: it raises the wake, raises the request a few cycles into the window, drops it, waits ten cycles and raises it again. The clock select is sampled on every cycle of this sequence, and the length of the final tail is measured.

// File: rtl/lpfc_pkg.sv
package lpfc_pkg;
  // power-mode codes
  localparam logic [3:0] PM_ACT0   = 4'd0;
  localparam logic [3:0] PM_ACT1   = 4'd1;
  localparam logic [3:0] PM_ACTLF  = 4'd2;
  localparam logic [3:0] PM_DOZE0  = 4'd3;
  localparam logic [3:0] PM_DOZE1  = 4'd4;
  localparam logic [3:0] PM_DOZELF = 4'd5;
  localparam logic [3:0] PM_HALTF  = 4'd6;
  localparam logic [3:0] PM_HALTG  = 4'd7;
  localparam logic [3:0] PM_HALTD  = 4'd8;
  localparam logic [3:0] PM_STBYO  = 4'd9;
  localparam logic [3:0] PM_STBYG  = 4'd10;

  localparam logic [1:0] SEL_LF  = 2'd0;
  localparam logic [1:0] SEL_OSC = 2'd1;
  localparam logic [1:0] SEL_OFF = 2'd2;

  localparam logic [1:0] FQ_4M  = 2'd0;
  localparam logic [1:0] FQ_32M = 2'd3;

  typedef enum logic [2:0] {
    CLS_FULL,
    CLS_LFRUN,
    CLS_GEAR,
    CLS_DEEP,
    CLS_GATED
  } mcls_e;

  typedef enum logic [1:0] {
    SQ_IDLE,
    SQ_WIN,
    SQ_HOLD,
    SQ_TAIL
  } sq_e;
endpackage

// File: rtl/lpfc_sync.sv
module lpfc_sync #(
  parameter int W      = 2,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stg [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < STAGES; i++) stg[i] <= '0;
    end else begin
      stg[0] <= d;
      for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
    end
  end

  assign q = stg[STAGES-1];
endmodule

// File: rtl/lpfc_mode_decode.sv
module lpfc_mode_decode
  import lpfc_pkg::*;
(
  input  logic [3:0] pm,
  output mcls_e      cls
);
  always_comb begin
    case (pm)
      PM_ACTLF, PM_DOZELF: cls = CLS_LFRUN;
      PM_HALTG:            cls = CLS_GEAR;
      PM_HALTD, PM_STBYO:  cls = CLS_DEEP;
      PM_STBYG:            cls = CLS_GATED;
      default:             cls = CLS_FULL;
    endcase
  end
endmodule

// File: rtl/lpfc_stby_seq.sv
module lpfc_stby_seq
  import lpfc_pkg::*;
#(
  parameter int WIN_CYC  = 32,
  parameter int TAIL_CYC = 32,
  parameter int TOW      = 8
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           gated_en,
  input  logic           wake_s,
  input  logic           req_s,
  output logic           busy_o,
  output logic           resume_o,
  output logic [TOW-1:0] tcnt_o
);
  localparam int MAXC = (WIN_CYC > TAIL_CYC) ? WIN_CYC : TAIL_CYC;
  localparam int CW   = (MAXC > 2) ? $clog2(MAXC) : 1;
  localparam logic [CW-1:0] WIN_LOAD  = CW'(WIN_CYC - 1);
  localparam logic [CW-1:0] TAIL_LOAD = CW'(TAIL_CYC - 1);

  sq_e            st;
  logic [CW-1:0]  cnt;
  logic           wk_d;
  logic           wake_rise;

  assign wake_rise = wake_s & ~wk_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st       <= SQ_IDLE;
      cnt      <= '0;
      wk_d     <= 1'b0;
      resume_o <= 1'b0;
      tcnt_o   <= '0;
    end else begin
      wk_d     <= wake_s;
      resume_o <= 1'b0;
      if (!gated_en) begin
        st  <= SQ_IDLE;
        cnt <= '0;
      end else begin
        case (st)
          SQ_IDLE: if (wake_rise) begin
            st  <= SQ_WIN;
            cnt <= WIN_LOAD;
          end
          SQ_WIN: begin
            if (req_s) st <= SQ_HOLD;
            else if (cnt == '0) begin
              st       <= SQ_IDLE;
              resume_o <= 1'b1;
              tcnt_o   <= tcnt_o + 1'b1;
            end else cnt <= cnt - 1'b1;
          end
          SQ_HOLD: if (!req_s) begin
            st  <= SQ_TAIL;
            cnt <= TAIL_LOAD;
          end
          SQ_TAIL: begin
            if (req_s) st <= SQ_HOLD;
            else if (cnt == '0) begin
              st       <= SQ_IDLE;
              resume_o <= 1'b1;
            end else cnt <= cnt - 1'b1;
          end
          default: st <= SQ_IDLE;
        endcase
      end
    end
  end

  assign busy_o = (st != SQ_IDLE);

  // R6: an empty window ends in idle with a resume pulse and one more timeout
  p_window_expire_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (gated_en && st == SQ_WIN && !req_s && cnt == '0) |=>
      (st == SQ_IDLE && resume_o && tcnt_o == TOW'($past(tcnt_o) + 1'b1)));

  // R7: release of a held request starts the tail
  p_hold_to_tail_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (gated_en && st == SQ_HOLD && !req_s) |=> (st == SQ_TAIL && cnt == TAIL_LOAD));

  // R8: a request during the tail cancels it
  p_tail_cancel_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (gated_en && st == SQ_TAIL && req_s) |=> (st == SQ_HOLD && !resume_o));

  // R5: a wake edge in idle opens the window
  p_wake_opens_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (gated_en && st == SQ_IDLE && wake_rise) |=> (st == SQ_WIN && cnt == WIN_LOAD));
endmodule

// File: rtl/lpfc_ctrl.sv
module lpfc_ctrl
  import lpfc_pkg::*;
#(
  parameter int WIN_CYC  = 32,
  parameter int TAIL_CYC = 32,
  parameter int SYNC_STG = 2,
  parameter int TOW      = 8
) (
  input  logic           clk_osc,
  input  logic           rst_n,
  input  logic [3:0]     pmode,
  input  logic           fclk_req,
  input  logic           tmr_wake,
  input  logic           ovr_run,
  input  logic           ovr_stop,
  input  logic [1:0]     base_freq,
  output logic           osc_en,
  output logic [1:0]     osc_freq,
  output logic [1:0]     clk_sel,
  output logic           lp_suspend,
  output logic           lp_resume,
  output logic [TOW-1:0] wake_timeouts
);
  mcls_e       cls;
  logic [1:0]  sync_q;
  logic        honour;
  logic        req_raw_h;
  logic        req_s_h;
  logic        wake_s;
  logic        seq_busy;

  assign honour    = ~ovr_run & ~ovr_stop;
  assign req_raw_h = fclk_req & honour;

  lpfc_sync #(.W(2), .STAGES(SYNC_STG)) u_sync (
    .clk   (clk_osc),
    .rst_n (rst_n),
    .d     ({tmr_wake, fclk_req}),
    .q     (sync_q)
  );

  assign req_s_h = sync_q[0] & honour;
  assign wake_s  = sync_q[1];

  lpfc_mode_decode u_dec (
    .pm  (pmode),
    .cls (cls)
  );

  lpfc_stby_seq #(.WIN_CYC(WIN_CYC), .TAIL_CYC(TAIL_CYC), .TOW(TOW)) u_seq (
    .clk      (clk_osc),
    .rst_n    (rst_n),
    .gated_en (cls == CLS_GATED),
    .wake_s   (wake_s),
    .req_s    (req_s_h),
    .busy_o   (seq_busy),
    .resume_o (lp_resume),
    .tcnt_o   (wake_timeouts)
  );

  always_comb begin
    osc_en     = 1'b0;
    osc_freq   = FQ_32M;
    clk_sel    = SEL_LF;
    lp_suspend = 1'b0;
    case (cls)
      CLS_FULL: begin
        osc_en   = 1'b1;
        osc_freq = base_freq;
        clk_sel  = SEL_OSC;
      end
      CLS_LFRUN: begin
        osc_en  = req_raw_h | req_s_h;
        clk_sel = req_s_h ? SEL_OSC : SEL_LF;
      end
      CLS_GEAR: begin
        osc_en   = 1'b1;
        osc_freq = req_s_h ? base_freq : FQ_4M;
        clk_sel  = SEL_OSC;
      end
      CLS_DEEP: begin
        osc_en     = req_raw_h | req_s_h;
        clk_sel    = req_s_h ? SEL_OSC : SEL_LF;
        lp_suspend = req_s_h;
      end
      CLS_GATED: begin
        osc_en     = seq_busy | tmr_wake | req_raw_h;
        clk_sel    = seq_busy ? SEL_OSC : SEL_OFF;
        lp_suspend = seq_busy;
      end
      default: ;
    endcase
  end

  // R2: the oscillator is never selected while it is disabled
  p_sel_needs_osc_r2: assert property (@(posedge clk_osc) disable iff (!rst_n)
    (clk_sel == SEL_OSC) |-> osc_en);

  // R8: no glitch on the select while the sequencer stays active
  p_sel_steady_r8: assert property (@(posedge clk_osc) disable iff (!rst_n)
    (seq_busy && $past(seq_busy) && $stable(pmode)) |-> (clk_sel == SEL_OSC && $stable(clk_sel)));

  // R9: with an override set, deep modes never suspend
  p_override_r9: assert property (@(posedge clk_osc) disable iff (!rst_n)
    (!honour && cls == CLS_DEEP) |-> !lp_suspend);
endmodule

// File: tb/sim_lpfc_ctrl.sv
module sim_lpfc_ctrl;
  logic       clk_osc = 1'b0;
  logic       rst_n;
  logic [3:0] pmode;
  logic       fclk_req, tmr_wake, ovr_run, ovr_stop;
  logic [1:0] base_freq;
  logic       osc_en, lp_suspend, lp_resume;
  logic [1:0] osc_freq, clk_sel;
  logic [7:0] wake_timeouts;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #5 clk_osc = ~clk_osc;

  lpfc_ctrl u0 (
    .clk_osc(clk_osc), .rst_n(rst_n), .pmode(pmode), .fclk_req(fclk_req),
    .tmr_wake(tmr_wake), .ovr_run(ovr_run), .ovr_stop(ovr_stop),
    .base_freq(base_freq), .osc_en(osc_en), .osc_freq(osc_freq),
    .clk_sel(clk_sel), .lp_suspend(lp_suspend), .lp_resume(lp_resume),
    .wake_timeouts(wake_timeouts)
  );

  task automatic step(input int n);
    repeat (n) @(posedge clk_osc);
    #1;
  endtask

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic t_reset;
    chk("R1 reset osc_en", osc_en, 1);
    chk("R1 reset freq", osc_freq, 2);
    chk("R1 reset sel", clk_sel, 1);
    chk("R1 reset suspend", lp_suspend, 0);
    chk("R6 reset timeouts", wake_timeouts, 0);
    chk("R7 reset resume", lp_resume, 0);
  endtask

  task automatic t_full;
    pmode = 4'd1; fclk_req = 1'b1; step(3);
    chk("R1 freq under req", osc_freq, 2);
    chk("R1 sel under req", clk_sel, 1);
    chk("R1 suspend under req", lp_suspend, 0);
    fclk_req = 1'b0; step(3);
  endtask

  task automatic t_lfrun;
    pmode = 4'd2; step(1);
    chk("R2 idle en", osc_en, 0);
    chk("R2 idle sel", clk_sel, 0);
    tmr_wake = 1'b1; step(4);
    chk("R11 wake ignored en", osc_en, 0);
    chk("R11 wake ignored sel", clk_sel, 0);
    tmr_wake = 1'b0; step(3);
    fclk_req = 1'b1; #1;
    chk("R10 raw en immediate", osc_en, 1);
    chk("R10 sel not yet", clk_sel, 0);
    step(1);
    chk("R10 sel after 1 edge", clk_sel, 0);
    step(1);
    chk("R2 sel req", clk_sel, 1);
    chk("R2 freq req", osc_freq, 3);
    chk("R2 no suspend", lp_suspend, 0);
    fclk_req = 1'b0; step(3);
    chk("R2 release en", osc_en, 0);
  endtask

  task automatic t_gear;
    pmode = 4'd7; step(1);
    chk("R3 idle freq", osc_freq, 0);
    chk("R3 idle en", osc_en, 1);
    fclk_req = 1'b1; step(2);
    chk("R3 req freq base", osc_freq, 2);
    fclk_req = 1'b0; step(2);
    chk("R3 release freq", osc_freq, 0);
    step(2);
  endtask

  task automatic t_deep;
    for (int m = 8; m <= 9; m++) begin
      pmode = 4'(m); step(1);
      fclk_req = 1'b1; step(2);
      chk("R4 suspend", lp_suspend, 1);
      chk("R4 sel", clk_sel, 1);
      chk("R4 freq", osc_freq, 3);
      fclk_req = 1'b0; step(2);
      chk("R4 release suspend", lp_suspend, 0);
      chk("R4 release en", osc_en, 0);
      chk("R4 release sel", clk_sel, 0);
    end
  endtask

  task automatic t_override;
    pmode = 4'd8;
    ovr_run = 1'b1; fclk_req = 1'b1; #1;
    chk("R9 run ovr en", osc_en, 0);
    step(3);
    chk("R9 run ovr suspend", lp_suspend, 0);
    chk("R9 run ovr sel", clk_sel, 0);
    ovr_run = 1'b0; ovr_stop = 1'b1; step(3);
    chk("R9 stop ovr en", osc_en, 0);
    chk("R9 stop ovr suspend", lp_suspend, 0);
    fclk_req = 1'b0; ovr_stop = 1'b0; step(3);
  endtask

  task automatic t_timeout;
    int n;
    pmode = 4'd10; step(2);
    chk("R5 gated idle en", osc_en, 0);
    chk("R5 gated idle sel", clk_sel, 2);
    tmr_wake = 1'b1; step(1);
    tmr_wake = 1'b0; step(2);
    chk("R5 wake suspend", lp_suspend, 1);
    chk("R5 wake sel", clk_sel, 1);
    chk("R5 wake en", osc_en, 1);
    chk("R5 wake freq", osc_freq, 3);
    n = 0;
    while (lp_suspend && n < 100) begin step(1); n++; end
    chk("R6 window length", n, 32);
    chk("R6 resume pulse", lp_resume, 1);
    chk("R6 timeout count", wake_timeouts, 1);
    chk("R6 back to gated", clk_sel, 2);
    step(1);
    chk("R6 resume one cycle", lp_resume, 0);
  endtask

  task automatic t_tail;
    int n;
    int bad;
    tmr_wake = 1'b1; step(1);
    tmr_wake = 1'b0; step(5);
    fclk_req = 1'b1; step(10);
    chk("R7 held sel", clk_sel, 1);
    fclk_req = 1'b0; step(10);
    fclk_req = 1'b1;
    bad = 0;
    for (int i = 0; i < 12; i++) begin
      step(1);
      if (clk_sel != 2'd1 || lp_resume) bad++;
    end
    chk("R8 sel kept through cancel", bad, 0);
    fclk_req = 1'b0;
    n = 0; bad = 0;
    while (lp_suspend && n < 100) begin
      step(1); n++;
      if (lp_suspend && clk_sel != 2'd1) bad++;
    end
    chk("R8 tail restarted length", n, 35);
    chk("R7 tail sel steady", bad, 0);
    chk("R7 resume pulse", lp_resume, 1);
    chk("R7 timeouts unchanged", wake_timeouts, 1);
    chk("R7 back to gated", clk_sel, 2);
  endtask

  initial begin
    rst_n = 1'b0; pmode = 4'd0; fclk_req = 1'b0; tmr_wake = 1'b0;
    ovr_run = 1'b0; ovr_stop = 1'b0; base_freq = 2'd2;
    step(3);
    rst_n = 1'b1; step(1);
    t_reset();
    t_full();
    t_lfrun();
    t_gear();
    t_deep();
    t_override();
    t_timeout();
    t_tail();
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #200000;
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog all requirements actual=hung expected=finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule